// File: doc/BRIEF.md
# Block-Based Memory Protection Filter

This filter sits in the path from a bus requester to a downstream memory. The address space is cut into equal blocks, and software keeps one security bit per block in a lookup table. Every transfer is looked up when it is accepted. A set bit marks the block as non-secure and a clear bit marks it as secure. A transfer goes through only when its secure attribute agrees with that marking; any other transfer is blocked.

An allowed transfer is sent to the memory port and its answer is returned to the requester. A blocked transfer never reaches the memory. The filter answers it itself, one cycle later. Depending on a control bit, the answer is either a normal completion (zero read data, write dropped) or a bus error. The first blocked transfer after the status was cleared is recorded in two capture registers and sets an interrupt status bit. Later blocked transfers are still refused but leave the record untouched until software clears the status.

A word-wide register port holds the control bit, the lookup table, the interrupt enable, set and clear strobes, the status and the two capture registers. Only one transfer is in flight at a time.

Top module: `blk_prot_filter`

## Requirements
- R1: The block index is the request address divided by BLK_BYTES (default 256). Its security bit is bit (index mod 32) of lookup word (index / 32), and lookup word w sits at register offset 0x100 + 4*w. An allowed transfer appears on the memory port with the same address, write flag and data. Its response carries the memory's read data, zero data for writes, and no error.
- R2: A lookup bit of 1 marks the block non-secure and a bit of 0 marks it secure. A transfer is blocked exactly when its secure attribute equals the block's lookup bit.
- R3: A blocked transfer never asserts the memory port's valid. Its response comes in the cycle after acceptance with zero read data, so a blocked write leaves memory unchanged.
- R4: Control register bit 0 (offset 0x00) selects the blocked response. When it is 1, the response has its error flag set. When it is 0, the response completes with the error flag clear.
- R5: When a transfer is blocked while the status bit is 0, capture register 1 (offset 0x2C) takes the zero-extended transfer address. Capture register 2 (offset 0x30) takes the requester ID in bits [15:0], the inverted secure attribute in bit 16 and the looked-up block bit in bit 17, with all other bits zero. In the same cycle the status bit (offset 0x20, bit 0) becomes 1.
- R6: While the status bit is 1, blocked transfers are still refused but neither capture register changes.
- R7: Writing 1 to bit 0 of the set register (offset 0x34) makes the status bit 1 without a transfer.
- R8: Writing 1 to bit 0 of the clear register (offset 0x24) makes the status bit 0, so the next blocked transfer is captured again. A set request or a capture in the same cycle takes priority over the clear.
- R9: The interrupt output equals, one cycle later, the AND of the status bit and enable register bit 0 (offset 0x28).
- R10: After reset, the control register, lookup table, status, enable and both capture registers read zero, and the interrupt output is low.
- R11: While an allowed transfer is in flight (issued or waiting for memory), req_ready is low. Every accepted transfer gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| req_master | input | 16 | Requester ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Response read data |
| rsp_error | output | 1 | Response bus error |
| mem_valid | output | 1 | Request to memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Memory address |
| mem_write | output | 1 | Memory write flag |
| mem_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rdata | input | DW | Memory read data |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt |

## Verification
The properties assume that the memory answers each accepted request with exactly one mem_rsp_valid pulse, and never sends one unprompted. They also assume that request fields stay steady while req_valid waits for req_ready. The stimulus holds every request until it is accepted and waits for its response before sending the next. The memory model stalls mem_ready on a fixed pattern and responds one cycle after each accepted beat. Register writes are issued between transfers, so a clear never meets a capture in the same cycle.

// File: rtl/blk_prot_pkg.sv
`timescale 1ns/1ps
package blk_prot_pkg;

   localparam int REG_AW = 12;

   localparam logic [REG_AW-1:0] OFS_CTRL = 12'h000;
   localparam logic [REG_AW-1:0] OFS_STAT = 12'h020;
   localparam logic [REG_AW-1:0] OFS_CLR  = 12'h024;
   localparam logic [REG_AW-1:0] OFS_IEN  = 12'h028;
   localparam logic [REG_AW-1:0] OFS_CAP1 = 12'h02C;
   localparam logic [REG_AW-1:0] OFS_CAP2 = 12'h030;
   localparam logic [REG_AW-1:0] OFS_SET  = 12'h034;
   localparam logic [REG_AW-1:0] OFS_LUT  = 12'h100;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_ISSUE = 2'd1,
      XS_WAIT  = 2'd2
   } xs_t;

   // second capture word: requester id, inverted secure flag, block bit
   function automatic logic [31:0] pack_cap2(input logic [15:0] master,
                                              input logic        secure,
                                              input logic        blk_ns);
      return {14'd0, blk_ns, ~secure, master};
   endfunction

endpackage

// File: rtl/bpf_lookup.sv
`timescale 1ns/1ps
module bpf_lookup #(
   parameter int AW        = 16,
   parameter int BLK_BYTES = 256,
   parameter int LUT_WORDS = 8
) (
   input  logic [AW-1:0]           addr,
   input  logic                    secure,
   input  logic [LUT_WORDS*32-1:0] lut_flat,
   output logic                    blk_ns,
   output logic                    blocked
);
   localparam int SH = $clog2(BLK_BYTES);
   localparam int IW = AW - SH;
   localparam int LB = LUT_WORDS * 32;
   localparam int XW = $clog2(LB);

   logic [IW-1:0] blk_idx;
   logic [XW-1:0] bit_sel;
   logic          unused_lo;

   assign blk_idx   = addr[AW-1:SH];
   assign unused_lo = ^addr[SH-1:0];
   // word = idx/32, bit = idx%32 is the same as bit idx of the flat table
   assign bit_sel   = XW'(blk_idx);
   assign blk_ns    = lut_flat[bit_sel];
   // secure attribute must be the opposite of the non-secure marking
   assign blocked   = (blk_ns == secure);

endmodule

// File: rtl/bpf_xfer.sv
`timescale 1ns/1ps
module bpf_xfer
   import blk_prot_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [DW-1:0] req_wdata,
   input  logic          blocked,
   input  logic          err_mode,
   output logic          blk_evt,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic          mem_write,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_error
);
   xs_t           state_q;
   logic [AW-1:0] addr_q;
   logic          wr_q;
   logic [DW-1:0] wdata_q;
   logic          accept;

   assign req_ready = (state_q == XS_IDLE);
   assign accept    = req_valid && req_ready;
   assign blk_evt   = accept && blocked;

   assign mem_valid = (state_q == XS_ISSUE);
   assign mem_addr  = addr_q;
   assign mem_write = wr_q;
   assign mem_wdata = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= XS_IDLE;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_error <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            XS_IDLE: begin
               if (accept) begin
                  if (blocked) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                     rsp_error <= err_mode;
                  end else begin
                     addr_q  <= req_addr;
                     wr_q    <= req_write;
                     wdata_q <= req_wdata;
                     state_q <= XS_ISSUE;
                  end
               end
            end
            XS_ISSUE: begin
               if (mem_ready) state_q <= XS_WAIT;
            end
            XS_WAIT: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= wr_q ? '0 : mem_rdata;
                  rsp_error <= 1'b0;
                  state_q   <= XS_IDLE;
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bpf_event.sv
`timescale 1ns/1ps
module bpf_event
   import blk_prot_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_evt,
   input  logic [AW-1:0] evt_addr,
   input  logic [15:0]   evt_master,
   input  logic          evt_secure,
   input  logic          evt_ns,
   input  logic          set_pulse,
   input  logic          clr_pulse,
   input  logic          irq_en,
   output logic          status_q,
   output logic [31:0]   cap1,
   output logic [31:0]   cap2,
   output logic          irq
);
   logic take;

   assign take = blk_evt && !status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         cap1     <= '0;
         cap2     <= '0;
      end else begin
         if (take) begin
            cap1 <= 32'(evt_addr);
            cap2 <= pack_cap2(evt_master, evt_secure, evt_ns);
         end
         // capture and software set win over a simultaneous clear
         if (take || set_pulse) status_q <= 1'b1;
         else if (clr_pulse)    status_q <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= status_q & irq_en;
         end
      end else begin : g_irq_comb
         assign irq = status_q & irq_en;
      end
   endgenerate

endmodule

// File: rtl/bpf_regs.sv
`timescale 1ns/1ps
module bpf_regs
   import blk_prot_pkg::*;
#(
   parameter int LUT_WORDS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wen,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata,
   input  logic                    status_q,
   input  logic [31:0]             cap1,
   input  logic [31:0]             cap2,
   output logic                    err_mode,
   output logic                    irq_en,
   output logic                    set_pulse,
   output logic                    clr_pulse,
   output logic [LUT_WORDS*32-1:0] lut_flat
);
   logic [31:0] lut_q [LUT_WORDS];

   assign set_pulse = reg_wen && (reg_addr == OFS_SET) && reg_wdata[0];
   assign clr_pulse = reg_wen && (reg_addr == OFS_CLR) && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_mode <= 1'b0;
         irq_en   <= 1'b0;
      end else if (reg_wen) begin
         if (reg_addr == OFS_CTRL) err_mode <= reg_wdata[0];
         if (reg_addr == OFS_IEN)  irq_en   <= reg_wdata[0];
      end
   end

   generate
      for (genvar w = 0; w < LUT_WORDS; w++) begin : g_lut
         localparam logic [REG_AW-1:0] WOFS = OFS_LUT + REG_AW'(4 * w);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lut_q[w] <= '0;
            else if (reg_wen && reg_addr == WOFS) lut_q[w] <= reg_wdata;
         end
         assign lut_flat[w*32 +: 32] = lut_q[w];
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL: reg_rdata = {31'd0, err_mode};
         OFS_STAT: reg_rdata = {31'd0, status_q};
         OFS_IEN:  reg_rdata = {31'd0, irq_en};
         OFS_CAP1: reg_rdata = cap1;
         OFS_CAP2: reg_rdata = cap2;
         default:  reg_rdata = '0;
      endcase
      for (int w = 0; w < LUT_WORDS; w++) begin
         if (reg_addr == OFS_LUT + REG_AW'(4 * w)) reg_rdata = lut_q[w];
      end
   end

endmodule

// File: rtl/blk_prot_filter.sv
`timescale 1ns/1ps
module blk_prot_filter
   import blk_prot_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int BLK_BYTES = 256,
   parameter bit IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_write,
   input  logic [DW-1:0]     req_wdata,
   input  logic              req_secure,
   input  logic [15:0]       req_master,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_error,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_write,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              reg_wen,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   localparam int SH        = $clog2(BLK_BYTES);
   localparam int NBLK      = 2 ** (AW - SH);
   localparam int LUT_WORDS = (NBLK + 31) / 32;

   generate
      if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_chk_blk
         $error("BLK_BYTES must be a power of two of at least 4");
      end
      if (AW > 32 || AW <= SH) begin : g_chk_aw
         $error("AW must exceed log2(BLK_BYTES) and be at most 32");
      end
      if (LUT_WORDS > 192) begin : g_chk_lut
         $error("lookup table does not fit the register window");
      end
      if (DW < 8) begin : g_chk_dw
         $error("DW must be at least 8");
      end
   endgenerate

   logic                    err_mode;
   logic                    irq_en;
   logic                    set_pulse;
   logic                    clr_pulse;
   logic [LUT_WORDS*32-1:0] lut_flat;
   logic                    blk_ns;
   logic                    blocked;
   logic                    blk_evt;
   logic                    status_q;
   logic [31:0]             cap1;
   logic [31:0]             cap2;

   bpf_regs #(.LUT_WORDS(LUT_WORDS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .status_q(status_q), .cap1(cap1), .cap2(cap2),
      .err_mode(err_mode), .irq_en(irq_en),
      .set_pulse(set_pulse), .clr_pulse(clr_pulse),
      .lut_flat(lut_flat)
   );

   bpf_lookup #(.AW(AW), .BLK_BYTES(BLK_BYTES), .LUT_WORDS(LUT_WORDS)) u_look (
      .addr(req_addr), .secure(req_secure), .lut_flat(lut_flat),
      .blk_ns(blk_ns), .blocked(blocked)
   );

   bpf_xfer #(.AW(AW), .DW(DW)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .blocked(blocked), .err_mode(err_mode), .blk_evt(blk_evt),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_write(mem_write), .mem_wdata(mem_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error)
   );

   bpf_event #(.AW(AW), .IRQ_REG(IRQ_REG)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .blk_evt(blk_evt), .evt_addr(req_addr), .evt_master(req_master),
      .evt_secure(req_secure), .evt_ns(blk_ns),
      .set_pulse(set_pulse), .clr_pulse(clr_pulse), .irq_en(irq_en),
      .status_q(status_q), .cap1(cap1), .cap2(cap2), .irq(irq)
   );

endmodule

// File: rtl/bpf_checker.sv
`timescale 1ns/1ps
module bpf_checker #(
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic          mem_valid,
   input logic          rsp_valid,
   input logic [DW-1:0] rsp_rdata,
   input logic          rsp_error,
   input logic          irq,
   input logic          blk_evt,
   input logic          err_mode,
   input logic          status_q,
   input logic          irq_en,
   input logic          set_pulse,
   input logic          clr_pulse,
   input logic [31:0]   cap1,
   input logic [31:0]   cap2
);

   assert_blk_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |=> rsp_valid && (rsp_rdata == '0));

   assert_no_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |=> !mem_valid);

   assert_err_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |=> rsp_error == $past(err_mode));

   assert_first_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_evt && !status_q) |=> status_q && (cap1 == 32'($past(req_addr))));

   assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_pulse) |=> status_q && $stable(cap1) && $stable(cap2));

   assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> status_q);

   assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && !set_pulse && !blk_evt) |=> !status_q);

   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !req_ready);

   generate
      if (IRQ_REG) begin : g_irq_chk
         assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(status_q & irq_en));
      end
   endgenerate

endmodule

bind blk_prot_filter bpf_checker #(.AW(AW), .DW(DW), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_addr(req_addr),
   .mem_valid(mem_valid), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .rsp_error(rsp_error), .irq(irq), .blk_evt(blk_evt), .err_mode(err_mode),
   .status_q(status_q), .irq_en(irq_en), .set_pulse(set_pulse),
   .clr_pulse(clr_pulse), .cap1(cap1), .cap2(cap2)
);

// File: tb/sim_blk_prot_filter.sv
`timescale 1ns/1ps
module sim_blk_prot_filter;
   import blk_prot_pkg::*;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int BLK = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready, req_write, req_secure;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic [15:0]   req_master;
   logic          rsp_valid, rsp_error;
   logic [DW-1:0] rsp_rdata;
   logic          mem_valid, mem_ready, mem_write, mem_rsp_valid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          reg_wen;
   logic [11:0]   reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic          irq;

   blk_prot_filter #(.AW(AW), .DW(DW), .BLK_BYTES(BLK)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata), .req_secure(req_secure),
      .req_master(req_master),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_write(mem_write), .mem_wdata(mem_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   always #4 clk = ~clk;

   // ---------------- downstream memory model ----------------
   logic [31:0] mem_arr [int];
   logic [2:0]  stall;
   assign mem_ready = (stall != 3'd1) && (stall != 3'd2);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall         <= '0;
         mem_rsp_valid <= 1'b0;
         mem_rdata     <= '0;
      end else begin
         stall         <= stall + 3'd1;
         mem_rsp_valid <= mem_valid && mem_ready;
         if (mem_valid && mem_ready) begin
            if (mem_write) begin
               mem_arr[int'(mem_addr) >> 2] = mem_wdata;
               mem_rdata <= 32'hDEAD_BEEF;
            end else begin
               mem_rdata <= mem_arr.exists(int'(mem_addr) >> 2) ?
                            mem_arr[int'(mem_addr) >> 2] : 32'd0;
            end
         end
      end
   end

   // ---------------- checking ----------------
   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   typedef struct {
      logic [31:0] d;
      logic        e;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   // monitor: pops one expected item per response
   always @(negedge clk) begin
      exp_t x;
      if (rst_n && rsp_valid) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R11", "unexpected response", 32'd1, 32'd0);
         end else begin
            x = sbq.pop_front();
            chk(rsp_rdata == x.d, x.tag, "rsp_rdata", rsp_rdata, x.d);
            chk(rsp_error == x.e, x.tag, "rsp_error", 32'(rsp_error), 32'(x.e));
         end
      end
   end

   // ---------------- reference model state ----------------
   bit          lut_sh [0:255];
   bit          ctrl_sh = 0;
   bit          en_sh   = 0;
   bit          st_sh   = 0;
   logic [31:0] c1_sh   = 0;
   logic [31:0] c2_sh   = 0;
   logic [31:0] sh_mem [int];

   task automatic xfer(input logic [15:0] a, input bit wr, input logic [31:0] wd,
                       input bit sec, input logic [15:0] m, input string tag);
      int   blk = int'(a) / BLK;
      bit   ns  = lut_sh[blk];
      bit   bl  = (ns == sec);
      int   key = int'(a) >> 2;
      int   guard = 0;
      exp_t x;
      x.tag = tag;
      if (bl) begin
         x.d = 0;
         x.e = ctrl_sh;
         if (!st_sh) begin
            c1_sh = 32'(a);
            c2_sh = {14'd0, ns, ~sec, m};
            st_sh = 1'b1;
         end
      end else begin
         x.e = 1'b0;
         if (wr) begin
            x.d = 0;
            sh_mem[key] = wd;
         end else begin
            x.d = sh_mem.exists(key) ? sh_mem[key] : 32'd0;
         end
      end
      sbq.push_back(x);
      @(negedge clk);
      req_valid  = 1'b1;
      req_addr   = a;
      req_write  = wr;
      req_wdata  = wd;
      req_secure = sec;
      req_master = m;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (sbq.size() != 0 && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      if (sbq.size() != 0) begin
         chk(1'b0, "R11", "missing response", 32'd0, 32'd1);
         sbq.delete();
      end
   endtask

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen   = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic reg_chk(input logic [11:0] a, input logic [31:0] exp,
                          input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, tag, $sformatf("reg 0x%03h", a), reg_rdata, exp);
   endtask

   task automatic lut_word(input int w, input logic [31:0] v);
      reg_wr(OFS_LUT + 12'(4 * w), v);
      for (int b = 0; b < 32; b++) lut_sh[w*32 + b] = v[b];
   endtask

   task automatic cap_chk(input string tag);
      reg_chk(OFS_CAP1, c1_sh, tag);
      reg_chk(OFS_CAP2, c2_sh, tag);
      reg_chk(OFS_STAT, 32'(st_sh), tag);
   endtask

   // irq is registered: settles one edge after status/enable
   task automatic irq_chk(input string tag);
      @(negedge clk);
      @(negedge clk);
      chk(irq == (st_sh & en_sh), tag, "irq", 32'(irq), 32'(st_sh & en_sh));
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) lut_sh[i] = 1'b0;
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_addr   = '0;
      req_write  = 1'b0;
      req_wdata  = '0;
      req_secure = 1'b0;
      req_master = '0;
      reg_wen    = 1'b0;
      reg_addr   = '0;
      reg_wdata  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      reg_chk(OFS_CTRL, 0, "R10");
      reg_chk(OFS_STAT, 0, "R10");
      reg_chk(OFS_IEN,  0, "R10");
      reg_chk(OFS_CAP1, 0, "R10");
      reg_chk(OFS_CAP2, 0, "R10");
      reg_chk(OFS_LUT,  0, "R10");
      reg_chk(OFS_LUT + 12'h01C, 0, "R10");
      chk(irq == 1'b0, "R10", "irq", 32'(irq), 0);
      chk(req_ready == 1'b1, "R11", "req_ready idle", 32'(req_ready), 1);

      // R1: all blocks secure, secure traffic passes
      xfer(16'h0010, 1, 32'hA1A1_0001, 1, 16'h0001, "R1");
      xfer(16'h0010, 0, 0,             1, 16'h0001, "R1");

      // R2/R5: non-secure read of a secure block is blocked and captured
      xfer(16'h0010, 0, 0, 0, 16'hA5C3, "R2");
      cap_chk("R5");
      irq_chk("R9");

      // R3/R6: blocked write dropped, capture held
      xfer(16'h0020, 1, 32'hB2B2_0002, 0, 16'h1234, "R3");
      cap_chk("R6");
      xfer(16'h0020, 0, 0, 1, 16'h0001, "R3");

      // R9: enable raises irq; R8: clear drops status
      reg_wr(OFS_IEN, 1); en_sh = 1'b1;
      irq_chk("R9");
      reg_wr(OFS_CLR, 1); st_sh = 1'b0;
      reg_chk(OFS_STAT, 0, "R8");
      irq_chk("R9");

      // block 3 non-secure, error mode on
      lut_word(0, 32'h0000_0008);
      reg_chk(OFS_LUT, 32'h0000_0008, "R1");
      reg_wr(OFS_CTRL, 1); ctrl_sh = 1'b1;
      reg_chk(OFS_CTRL, 1, "R4");
      xfer(16'h0304, 1, 32'hC3C3_0003, 0, 16'h0042, "R2");
      xfer(16'h0304, 0, 0,             0, 16'h0042, "R2");
      // R4: secure read of non-secure block gives an error; R8 recapture
      xfer(16'h0308, 0, 0, 1, 16'h7E01, "R4");
      cap_chk("R8");
      irq_chk("R9");
      xfer(16'h0304, 1, 32'hFFFF_FFFF, 1, 16'h0009, "R4");
      xfer(16'h0304, 0, 0,             0, 16'h0009, "R3");

      // R1: mapping across the word boundary (block 37 = word 1 bit 5)
      reg_wr(OFS_CLR, 1); st_sh = 1'b0;
      lut_word(1, 32'h0000_0020);
      xfer(16'h2500, 1, 32'hE5E5_0005, 0, 16'h0100, "R1");
      xfer(16'h2500, 0, 0,             0, 16'h0100, "R1");
      xfer(16'h2400, 0, 0,             0, 16'h0200, "R1");
      cap_chk("R5");

      // R7: software set, later blocked transfer not captured
      reg_wr(OFS_CLR, 1); st_sh = 1'b0;
      reg_wr(OFS_SET, 1); st_sh = 1'b1;
      reg_chk(OFS_STAT, 1, "R7");
      irq_chk("R7");
      xfer(16'hFF00, 0, 0, 0, 16'h0300, "R7");
      cap_chk("R7");

      // last block (word 7 bit 31), normal-completion mode
      lut_word(7, 32'h8000_0000);
      reg_wr(OFS_CTRL, 0); ctrl_sh = 1'b0;
      reg_wr(OFS_CLR, 1);  st_sh = 1'b0;
      xfer(16'hFFFC, 1, 32'hF6F6_0006, 0, 16'h0400, "R1");
      xfer(16'hFFFC, 0, 0,             0, 16'h0400, "R1");
      xfer(16'hFFF0, 0, 0,             1, 16'hBEEF, "R4");
      cap_chk("R5");
      irq_chk("R9");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule